// File: doc/BRIEF.md
# Progressive and Interlaced Display Timing Generator

This block runs on the pixel clock. It produces the raster timing for a display output: horizontal sync, vertical sync, data-enable, a field flag and a one-cycle frame-start pulse that can feed an interrupt. Horizontal timing is one set of four counts: sync, back porch, active and front porch. Vertical timing comes in two independent sets of the same four counts, one for each field.

In progressive mode only the first vertical set is used, and every field is a full frame. In interlaced mode the block alternates field by field between the two vertical sets. Software normally programs each field's active count as half the frame's lines. It also programs the second field's back porch one line longer than the first, which gives the half-line offset between fields.

All timing, mode and polarity inputs pass through shadow registers. While the block is enabled, a new configuration takes effect only on a frame boundary.

Top module: `vid_timing_gen`

## Requirements
- R1: A line is the sequence sync, back porch, active, front porch. Each phase lasts its programmed count plus one pixel clocks, and hsync is active for exactly the sync phase.
- R2: A field is the same four-phase sequence counted in lines. Each phase lasts its programmed count plus one lines. vsync is active for the sync lines and changes state only at the first pixel of a line, together with the start of hsync.
- R3: de_o is high only while both the horizontal and the vertical position are in their active phases. In the first active line it rises (h_sync+1)+(h_bp+1) cycles after the line start and stays high for h_act+1 cycles.
- R4: With hs_pol_i or vs_pol_i at 1, the matching sync output is active-low and idles high. With the bit at 0 the output is active-high and idles low.
- R5: Interlaced mode is selected only when scan_ilace_i and scan_pi_i are both 1. Any other combination gives progressive mode, which uses only the f0_* set and holds field_o at 0.
- R6: In interlaced mode the fields alternate. The second field uses the f1_* set, including its own 16-bit active-line count.
- R7: field_o is 0 in the first field and 1 in the second. It changes on the first cycle after a field's front porch ends, in the same cycle as the next field's vsync start.
- R8: frame_start_o is a one-cycle pulse on the first pixel of a first field. Progressive mode gives one pulse per field. Interlaced mode gives one pulse per pair of fields.
- R9: While en_i is high, changes on the timing inputs take effect only from the next frame boundary. In interlaced mode that boundary is the end of the second field.
- R10: With en_i low, the outputs go inactive one clock after en_i is sampled low: de, field and frame-start at 0, syncs at their idle level. The counters return to the start of the first field. The first clock with en_i high shows the first pixel of a first field, including a frame-start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the counters and loads the shadow registers |
| scan_ilace_i | input | 1 | Interlace select bit |
| scan_pi_i | input | 1 | Progressive/interlace enable bit |
| hs_pol_i | input | 1 | 1 makes hsync active-low |
| vs_pol_i | input | 1 | 1 makes vsync active-low |
| h_sync_i | input | HW | Horizontal sync width minus one |
| h_bp_i | input | HW | Horizontal back porch minus one |
| h_act_i | input | HW | Horizontal active width minus one |
| h_fp_i | input | HW | Horizontal front porch minus one |
| f0_vsync_i | input | VW | First-field vsync lines minus one |
| f0_vbp_i | input | VW | First-field back porch lines minus one |
| f0_vact_i | input | VW | First-field active lines minus one |
| f0_vfp_i | input | VW | First-field front porch lines minus one |
| f1_vsync_i | input | VW | Second-field vsync lines minus one |
| f1_vbp_i | input | VW | Second-field back porch lines (software adds the extra line) |
| f1_vact_i | input | VW | Second-field active lines minus one (16 bits by default) |
| f1_vfp_i | input | VW | Second-field front porch lines minus one |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Current field, 0 first, 1 second |
| frame_start_o | output | 1 | One-cycle pulse at the start of a frame |

## Verification
Each output is registered once after the counter state. The first clock edge that samples en_i high therefore makes index 0 of the captured trace the first pixel of a first field. Dropping en_i makes the outputs inactive after a single edge. The bench samples on the falling edge and records a trace from the first cycle after enabling. It then checks each result at the index that follows from the programmed counts, for example de at line 3 plus 4 pixels and the second field at cycle 70. A register change made mid-frame is checked at both sides of the frame boundary: line period 10 before cycle 160 and 12 after it.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_BP   = 2'd1,
    PH_ACT  = 2'd2,
    PH_FP   = 2'd3
  } phase_e;

  function automatic phase_e next_phase(phase_e p);
    unique case (p)
      PH_SYNC: return PH_BP;
      PH_BP:   return PH_ACT;
      PH_ACT:  return PH_FP;
      default: return PH_SYNC;
    endcase
  endfunction
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow #(
  parameter int HW = 12,
  parameter int VW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [3:0][HW-1:0]  h_raw_i,
  input  logic [3:0][VW-1:0]  v0_raw_i,
  input  logic [3:0][VW-1:0]  v1_raw_i,
  input  logic                ilace_sel_i,
  input  logic                pi_en_i,
  input  logic                hpol_i,
  input  logic                vpol_i,
  output logic [3:0][HW-1:0]  h_len_o,
  output logic [3:0][VW-1:0]  v0_len_o,
  output logic [3:0][VW-1:0]  v1_len_o,
  output logic                ilace_o,
  output logic                hpol_o,
  output logic                vpol_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_len_o  <= '0;
      v0_len_o <= '0;
      v1_len_o <= '0;
      ilace_o  <= 1'b0;
      hpol_o   <= 1'b0;
      vpol_o   <= 1'b0;
    end else if (load_i) begin
      h_len_o  <= h_raw_i;
      v0_len_o <= v0_raw_i;
      v1_len_o <= v1_raw_i;
      // both scan bits needed for interlace
      ilace_o  <= ilace_sel_i & pi_en_i;
      hpol_o   <= hpol_i;
      vpol_o   <= vpol_i;
    end
  end

  // R9: configuration frozen between load points
  a_r9_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(h_len_o) && $stable(v0_len_o) && $stable(v1_len_o)
                 && $stable(ilace_o) && $stable(hpol_o) && $stable(vpol_o)));
endmodule

// File: rtl/vtg_phase_ctr.sv
module vtg_phase_ctr
  import vtg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               step_i,
  input  logic [3:0][W-1:0]  len_i,
  output phase_e             ph_o,
  output logic [W-1:0]       cnt_o,
  output logic               last_o
);
  phase_e         ph_q;
  logic [W-1:0]   cnt_q;
  logic           ph_end;

  assign ph_end = (cnt_q == len_i[ph_q]);
  assign last_o = ph_end && (ph_q == PH_FP);
  assign ph_o   = ph_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_SYNC;
      cnt_q <= '0;
    end else if (clr_i) begin
      ph_q  <= PH_SYNC;
      cnt_q <= '0;
    end else if (step_i) begin
      if (ph_end) begin
        ph_q  <= next_phase(ph_q);
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R1, R2: a phase never runs past its programmed length
  a_r1_cnt_within_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len_i[ph_q]);

  // R2: counter only moves on a step
  a_r2_hold_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> ($stable(cnt_q) && $stable(ph_q)));
endmodule

// File: rtl/vtg_field_seq.sv
module vtg_field_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ilace_i,
  input  logic line_end_i,
  input  logic field_last_i,
  output logic field_o,
  output logic frame_end_o
);
  logic field_q;
  logic field_end;

  assign field_end   = en_i && line_end_i && field_last_i;
  assign frame_end_o = field_end && (!ilace_i || field_q);
  assign field_o     = field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        field_q <= 1'b0;
    else if (!en_i)     field_q <= 1'b0;
    else if (field_end) field_q <= ilace_i && !field_q;
  end

  // R5: second field exists only in interlaced mode
  a_r5_field_needs_ilace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_q |-> ilace_i);

  // R7: field flips only at a field end
  a_r7_field_change_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !field_end) |=> $stable(field_q));
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          scan_ilace_i,
  input  logic          scan_pi_i,
  input  logic          hs_pol_i,
  input  logic          vs_pol_i,
  input  logic [HW-1:0] h_sync_i,
  input  logic [HW-1:0] h_bp_i,
  input  logic [HW-1:0] h_act_i,
  input  logic [HW-1:0] h_fp_i,
  input  logic [VW-1:0] f0_vsync_i,
  input  logic [VW-1:0] f0_vbp_i,
  input  logic [VW-1:0] f0_vact_i,
  input  logic [VW-1:0] f0_vfp_i,
  input  logic [VW-1:0] f1_vsync_i,
  input  logic [VW-1:0] f1_vbp_i,
  input  logic [VW-1:0] f1_vact_i,
  input  logic [VW-1:0] f1_vfp_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          field_o,
  output logic          frame_start_o
);
  logic [3:0][HW-1:0] h_len;
  logic [3:0][VW-1:0] v0_len, v1_len, v_len;
  logic               ilace_q, hpol_q, vpol_q;
  logic               load;
  logic               frame_end;
  logic               field_q;
  phase_e             hph, vph;
  logic [HW-1:0]      hcnt;
  logic [VW-1:0]      vcnt;
  logic               h_last, v_last;
  logic               at_origin;

  assign load = !en_i || frame_end;

  vtg_shadow #(.HW(HW), .VW(VW)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .h_raw_i     ({h_fp_i, h_act_i, h_bp_i, h_sync_i}),
    .v0_raw_i    ({f0_vfp_i, f0_vact_i, f0_vbp_i, f0_vsync_i}),
    .v1_raw_i    ({f1_vfp_i, f1_vact_i, f1_vbp_i, f1_vsync_i}),
    .ilace_sel_i (scan_ilace_i),
    .pi_en_i     (scan_pi_i),
    .hpol_i      (hs_pol_i),
    .vpol_i      (vs_pol_i),
    .h_len_o     (h_len),
    .v0_len_o    (v0_len),
    .v1_len_o    (v1_len),
    .ilace_o     (ilace_q),
    .hpol_o      (hpol_q),
    .vpol_o      (vpol_q)
  );

  vtg_phase_ctr #(.W(HW)) u_hctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!en_i),
    .step_i (1'b1),
    .len_i  (h_len),
    .ph_o   (hph),
    .cnt_o  (hcnt),
    .last_o (h_last)
  );

  assign v_len = field_q ? v1_len : v0_len;

  vtg_phase_ctr #(.W(VW)) u_vctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!en_i),
    .step_i (h_last),
    .len_i  (v_len),
    .ph_o   (vph),
    .cnt_o  (vcnt),
    .last_o (v_last)
  );

  vtg_field_seq u_field (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .ilace_i      (ilace_q),
    .line_end_i   (h_last),
    .field_last_i (v_last),
    .field_o      (field_q),
    .frame_end_o  (frame_end)
  );

  assign at_origin = (hph == PH_SYNC) && (hcnt == '0) &&
                     (vph == PH_SYNC) && (vcnt == '0) && !field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o       <= 1'b0;
      vsync_o       <= 1'b0;
      de_o          <= 1'b0;
      field_o       <= 1'b0;
      frame_start_o <= 1'b0;
    end else if (!en_i) begin
      hsync_o       <= hpol_q;
      vsync_o       <= vpol_q;
      de_o          <= 1'b0;
      field_o       <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      hsync_o       <= (hph == PH_SYNC) ^ hpol_q;
      vsync_o       <= (vph == PH_SYNC) ^ vpol_q;
      de_o          <= (hph == PH_ACT) && (vph == PH_ACT);
      field_o       <= field_q;
      frame_start_o <= at_origin;
    end
  end

  // R8: single-cycle pulse, first field only
  a_r8_fs_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
  a_r8_fs_first_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> !field_o);
  // R10: disable silences the outputs after one edge
  a_r10_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!de_o && !frame_start_o && !field_o));
  // R3: data enable never overlaps horizontal sync
  a_r3_de_outside_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && $stable(hpol_q)) |-> (hsync_o == hpol_q));
endmodule

// File: tb/tb_vid_timing_gen.sv
`timescale 1ns/1ps
module tb_vid_timing_gen;
  localparam int HW  = 12;
  localparam int VW  = 16;
  localparam int CAP = 400;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, sel = 1'b0, pie = 1'b0, hpol = 1'b0, vpol = 1'b0;
  logic [HW-1:0] hs = 1, hb = 1, ha = 3, hf = 1;
  logic [VW-1:0] v0s = 0, v0b = 1, v0a = 2, v0f = 0;
  logic [VW-1:0] v1s = 1, v1b = 2, v1a = 1, v1f = 1;
  logic hsync, vsync, de, field, fstart;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [4:0] cap [CAP];

  always #5 clk = ~clk;

  vid_timing_gen #(.HW(HW), .VW(VW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en),
    .scan_ilace_i(sel), .scan_pi_i(pie), .hs_pol_i(hpol), .vs_pol_i(vpol),
    .h_sync_i(hs), .h_bp_i(hb), .h_act_i(ha), .h_fp_i(hf),
    .f0_vsync_i(v0s), .f0_vbp_i(v0b), .f0_vact_i(v0a), .f0_vfp_i(v0f),
    .f1_vsync_i(v1s), .f1_vbp_i(v1b), .f1_vact_i(v1a), .f1_vfp_i(v1f),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .field_o(field),
    .frame_start_o(fstart)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // bit 0 hs, 1 vs, 2 de, 3 field, 4 frame start; syncs normalised to active-high
  function automatic int rise_at(int b, int from);
    for (int i = from; i < CAP; i++)
      if (cap[i][b] && (i == 0 || !cap[i-1][b])) return i;
    return -1;
  endfunction

  function automatic int run_len(int b, int idx);
    int n = 0;
    if (idx < 0) return -1;
    for (int i = idx; i < CAP; i++) begin
      if (!cap[i][b]) break;
      n++;
    end
    return n;
  endfunction

  function automatic int rises_in(int b, int lo, int hi);
    int n = 0;
    for (int i = lo; i < hi; i++)
      if (cap[i][b] && (i == 0 || !cap[i-1][b])) n++;
    return n;
  endfunction

  function automatic int high_cnt(int b);
    int n = 0;
    for (int i = 0; i < CAP; i++) if (cap[i][b]) n++;
    return n;
  endfunction

  task automatic restart();
    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
  endtask

  task automatic capture(input int chg_at, input logic [HW-1:0] new_ha);
    for (int i = 0; i < CAP; i++) begin
      @(negedge clk);
      cap[i] = {fstart, field, de, vsync ^ vpol, hsync ^ hpol};
      if (i == chg_at) ha = new_ha;
    end
  endtask

  task automatic t_reset();
    chk("R10 reset hsync", int'(hsync), 0);
    chk("R10 reset de", int'(de), 0);
    chk("R10 reset frame_start", int'(fstart), 0);
  endtask

  task automatic t_progressive();
    sel = 0; pie = 0;
    restart();
    capture(-1, ha);
    chk("R10 frame start first cycle", int'(cap[0][4]), 1);
    chk("R1 hsync width", run_len(0, 0), 2);
    chk("R1 line period", rise_at(0, 1), 10);
    chk("R3 first de position", rise_at(2, 0), 34);
    chk("R3 de width", run_len(2, 34), 4);
    chk("R2 vsync lines", run_len(1, 0), 10);
    chk("R2 next vsync", rise_at(1, 1), 70);
    chk("R3 active lines", rises_in(2, 0, 70), 3);
    chk("R8 progressive pulse spacing", rise_at(4, 1), 70);
    chk("R5 field stays 0", high_cnt(3), 0);
  endtask

  task automatic t_mixed_mode();
    sel = 1; pie = 0;
    restart();
    capture(-1, ha);
    chk("R5 one bit gives progressive", rise_at(4, 1), 70);
    chk("R5 one bit field 0", high_cnt(3), 0);
  endtask

  task automatic t_interlace();
    sel = 1; pie = 1;
    restart();
    capture(-1, ha);
    chk("R8 one pulse per two fields", rise_at(4, 1), 160);
    chk("R8 no pulse in second field", rises_in(4, 1, 160), 0);
    chk("R7 field rises after fp", rise_at(3, 0), 70);
    chk("R6 second field length", run_len(3, 70), 90);
    chk("R7 field with vsync", rise_at(1, 1), 70);
    chk("R6 second vsync lines", run_len(1, 70), 20);
    chk("R6 second field de position", rise_at(2, 70), 124);
    chk("R6 second field active lines", rises_in(2, 70, 160), 2);
    chk("R6 first field active lines", rises_in(2, 0, 70), 3);
  endtask

  task automatic t_polarity();
    sel = 0; pie = 0; hpol = 1; vpol = 1;
    restart();
    @(negedge clk);
    chk("R4 hsync low when active", int'(hsync), 0);
    chk("R4 vsync low when active", int'(vsync), 0);
    repeat (4) @(negedge clk);
    chk("R4 hsync idles high", int'(hsync), 1);
    repeat (10) @(negedge clk);
    chk("R4 vsync idles high", int'(vsync), 1);
    hpol = 0; vpol = 0;
  endtask

  task automatic t_shadow();
    sel = 1; pie = 1;
    restart();
    capture(20, 12'd5);
    chk("R9 old line period kept", rise_at(0, 141), 150);
    chk("R9 frame boundary unchanged", rise_at(4, 1), 160);
    chk("R9 new line period after frame", rise_at(0, 161), 172);
    ha = 3;
  endtask

  task automatic t_disable();
    sel = 1; pie = 1;
    restart();
    repeat (100) @(negedge clk);
    chk("R7 in second field", int'(field), 1);
    en = 1'b0;
    @(negedge clk);
    chk("R10 de off", int'(de), 0);
    chk("R10 field cleared", int'(field), 0);
    chk("R10 hsync idle", int'(hsync), 0);
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk("R10 restart pulse", int'(fstart), 1);
    chk("R10 restart hsync", int'(hsync), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(fstart), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_progressive();
    t_mixed_mode();
    t_interlace();
    t_polarity();
    t_shadow();
    t_disable();
    finish_run();
  end
endmodule